// File: doc/BRIEF.md
# Synchronous Serial Port Master

This block is a register-mapped serial master for peripherals such as flash, sensors and converters. Software programs the frame size, clock polarity, clock phase and bit rate, pushes words into a transmit queue, and pops received words from a receive queue. The block then runs one frame per queued word. For each frame it drives a serial clock, a data output and an active-low frame select, and it samples a data input. Frames go out most significant bit first.

The bit rate comes from two dividers in series. The first is an even prescaler. The second divides by (1 + rate). A loopback mode feeds the transmit shifter straight into the receive shifter, so software can test the data path with nothing attached to the pins.

The register bus takes one access per cycle and applies no back-pressure, so it is always ready. Flow control is the job of software, which reads the status flags before it writes or reads the data register:
- A write to a full transmit queue is dropped.
- A read of an empty receive queue returns zero and changes nothing.
- A frame that completes while the receive queue is full is discarded, and the overrun flag is set.

Top module: `ssp_master`

## Requirements
- R1: After reset, the serial clock is 0, the frame select is high and the interrupt output is 0. Control register 0 (offset 0x00) reads 0, and the status register (offset 0x0C) reads 0x0B.
- R2: The status register holds these flags: bit 0 = transmit queue empty, bit 1 = transmit queue not full, bit 2 = receive queue not empty, bit 3 = receive queue not full, bit 4 = busy. Busy is set while a frame is in progress or the transmit queue holds data.
- R3: A frame holds frame select low for exactly 2·N·H clock cycles, where N is the frame size in bits and H = (P/2)·(1+S). P is the prescale register (offset 0x10) with bit 0 read as 0 and ignored. S is bits 15:8 of control register 0.
- R4: Bits 3:0 of control register 0 hold the frame size minus one (7 gives 8-bit frames, 15 gives 16-bit frames). The low N bits of a data-register write (offset 0x08) are sent MSB first. A received frame reads back right-aligned, with the upper bits zero.
- R5: Bit 6 of control register 0 is the clock polarity and sets the idle level of the serial clock. Bit 7 is the phase: with phase 0 the input is sampled on the leading clock edge, and with phase 1 on the trailing edge. The output changes on the opposite edge.
- R6: Control register 1 (offset 0x04) bit 0 selects loopback. In loopback each transmitted word is received unchanged, and the data input pin is ignored.
- R7: While control register 1 bit 1 (enable) is 0, no frame starts: frame select stays high and the serial clock rests at the polarity level. Writes to the data register are still queued.
- R8: Each queue holds 8 words. A 9th write to the transmit queue is dropped. Reads of the data register return received words in arrival order.
- R9: A frame that completes while the receive queue is full is discarded, and raw interrupt bit 0 (overrun) is set.
- R10: Raw interrupt bit 1 (timeout) sets when the receive queue stays non-empty for 32 serial clock periods with no read and no new frame.
- R11: A write to the clear register (offset 0x20) clears raw bit 0 where the write data bit 0 is 1, and raw bit 1 where write data bit 1 is 1. It does not affect the other raw bits.
- R12: Raw status (offset 0x18) bit 2 is 1 when the receive queue holds 4 or more words. Bit 3 is 1 when the transmit queue holds 4 or fewer words. Masked status (offset 0x1C) equals raw status AND the mask register (offset 0x14). The interrupt output is the OR of the masked bits.
- R13: Control register 1 bits 2 and 3 and control register 0 bits 5:4 are stored and read back but have no effect: frames still run as a master serial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the access cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fs_n | output | 1 | Active-low frame select |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is a frame completing against a full receive queue. Eight loopback frames must land first, and one more word must then be sent before any read. The bench fills both queues while the port is disabled, enables it with the fastest divider, and sends the extra word. It then reads all eight words back, to show that the extra frame was dropped, not written over the oldest one. Phase and polarity are checked against a bench-side peripheral model, which follows the serial clock edges, shifts its own word out, and records the data-out pin on the sample edges.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFF_CTL0 = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_CTL1 = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_DATA = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_STAT = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_PRE  = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_IMSK = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_RAW  = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_MSK  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFF_ICLR = 6'h20;
  typedef enum logic {SH_IDLE, SH_RUN} shift_state_e;
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop |=> $stable(count)); // R8
endmodule

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
  parameter int PW = 8,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [PW-1:0] prescale,
  input  logic [SW-1:0] rate,
  output logic          half_tick
);
  logic [PW-2:0] pre_cnt;
  logic [SW-1:0] rate_cnt;
  logic [PW-2:0] pre_lim;
  logic          pre_tick;

  assign pre_lim   = (prescale[PW-1:1] == '0) ? '0 : prescale[PW-1:1] - 1'b1;
  assign pre_tick  = (pre_cnt == pre_lim);
  assign half_tick = pre_tick && (rate_cnt == rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      rate_cnt <= '0;
    end else if (clr) begin
      pre_cnt <= '0;
      rate_cnt <= '0;
    end else if (pre_tick) begin
      pre_cnt <= '0;
      rate_cnt <= (rate_cnt == rate) ? '0 : rate_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter
  import ssp_pkg::*;
#(
  parameter int DW = 16,
  parameter int SZW = 4,
  localparam int EW = $clog2(2 * DW + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           cpol,
  input  logic           cpha,
  input  logic           loopback,
  input  logic [SZW-1:0] size_m1,
  input  logic           half_tick,
  input  logic           tx_avail,
  input  logic [DW-1:0]  tx_word,
  output logic           load,
  output logic           rx_push,
  output logic [DW-1:0]  rx_word,
  input  logic           miso,
  output logic           sclk,
  output logic           mosi,
  output logic           fs_n
);
  shift_state_e  st;
  logic          ph, mosi_q, din, smp, shout, run_tick;
  logic [EW-1:0] edges_left;
  logic [DW-1:0] txsr, rxsr, rx_nxt, aligned, mask;
  logic [SZW:0]  nbits;

  assign nbits    = {1'b0, size_m1} + 1'b1;
  assign aligned  = tx_word << (DW - int'(nbits));
  assign mask     = DW'((32'd1 << nbits) - 32'd1);
  assign load     = en && (st == SH_IDLE) && tx_avail;
  assign run_tick = (st == SH_RUN) && half_tick;
  assign smp      = run_tick && (cpha ? ph : !ph);
  assign shout    = run_tick && (cpha ? !ph : ph);
  assign din      = loopback ? mosi_q : miso;
  assign rx_nxt   = smp ? {rxsr[DW-2:0], din} : rxsr;
  assign rx_push  = en && run_tick && (edges_left == EW'(1));
  assign rx_word  = rx_nxt & mask;
  assign sclk     = cpol ^ ph;
  assign mosi     = mosi_q;
  assign fs_n     = (st == SH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SH_IDLE;
      ph <= 1'b0;
      edges_left <= '0;
      txsr <= '0;
      rxsr <= '0;
      mosi_q <= 1'b0;
    end else if (!en) begin
      st <= SH_IDLE;
      ph <= 1'b0;
    end else if (st == SH_IDLE) begin
      if (tx_avail) begin
        st <= SH_RUN;
        ph <= 1'b0;
        edges_left <= EW'({nbits, 1'b0});
        rxsr <= '0;
        if (!cpha) begin
          mosi_q <= aligned[DW-1];
          txsr <= aligned << 1;
        end else begin
          txsr <= aligned;
        end
      end
    end else if (half_tick) begin
      ph <= ~ph;
      edges_left <= edges_left - 1'b1;
      rxsr <= rx_nxt;
      if (shout) begin
        mosi_q <= txsr[DW-1];
        txsr <= txsr << 1;
      end
      if (edges_left == EW'(1)) st <= SH_IDLE;
    end
  end

  AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fs_n |-> (sclk == cpol)); // R5
  AST_DISABLED_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> fs_n); // R7
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
#(
  parameter int DW = 16,
  parameter int DEPTH = 8,
  parameter int TO_PERIODS = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TO_HALVES = 2 * TO_PERIODS,
  localparam int TW = $clog2(TO_HALVES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              fs_n,
  output logic              irq
);
  logic [15:0]   ctl0;
  logic [3:0]    ctl1, imsk;
  logic [7:0]    pre;
  logic          ovr_raw, to_raw;
  logic [TW-1:0] to_cnt;
  logic          wr, rd, tx_push, rx_pop, load, rx_push, half_tick;
  logic [DW-1:0] tx_dout, rx_dout, rx_word;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          tx_full, tx_empty, rx_full, rx_empty, busy, to_reset;
  logic [3:0]    raw, masked;
  logic [4:0]    status;

  assign wr      = bus_sel && bus_we;
  assign rd      = bus_sel && !bus_we;
  assign tx_push = wr && (bus_addr == OFF_DATA);
  assign rx_pop  = rd && (bus_addr == OFF_DATA);

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .push(tx_push), .pop(load), .din(DW'(bus_wdata)),
    .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  ssp_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_push), .pop(rx_pop), .din(rx_word),
    .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  ssp_clkdiv #(.PW(8), .SW(8)) u_div (
    .clk, .rst_n, .clr(load || !ctl1[1]), .prescale(pre), .rate(ctl0[15:8]),
    .half_tick);

  ssp_shifter #(.DW(DW), .SZW(4)) u_shf (
    .clk, .rst_n, .en(ctl1[1]), .cpol(ctl0[6]), .cpha(ctl0[7]),
    .loopback(ctl1[0]), .size_m1(ctl0[3:0]), .half_tick,
    .tx_avail(!tx_empty), .tx_word(tx_dout), .load, .rx_push, .rx_word,
    .miso, .sclk, .mosi, .fs_n);

  assign busy   = !fs_n || !tx_empty;
  assign status = {busy, !rx_full, !rx_empty, !tx_full, tx_empty};
  assign raw    = {tx_cnt <= CW'(DEPTH / 2), rx_cnt >= CW'(DEPTH / 2), to_raw, ovr_raw};
  assign masked = raw & imsk;
  assign irq    = |masked;
  assign to_reset = rx_empty || rx_pop || rx_push;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0 <= '0;
      ctl1 <= '0;
      pre <= '0;
      imsk <= '0;
      ovr_raw <= 1'b0;
      to_raw <= 1'b0;
      to_cnt <= '0;
    end else begin
      if (wr && bus_addr == OFF_CTL0) ctl0 <= bus_wdata;
      if (wr && bus_addr == OFF_CTL1) ctl1 <= bus_wdata[3:0];
      if (wr && bus_addr == OFF_PRE)  pre <= {bus_wdata[7:1], 1'b0};
      if (wr && bus_addr == OFF_IMSK) imsk <= bus_wdata[3:0];
      if (to_reset) to_cnt <= '0;
      else if (half_tick && to_cnt != TW'(TO_HALVES)) to_cnt <= to_cnt + 1'b1;
      if (rx_push && rx_full) ovr_raw <= 1'b1;
      else if (wr && bus_addr == OFF_ICLR && bus_wdata[0]) ovr_raw <= 1'b0;
      if (!to_reset && half_tick && to_cnt == TW'(TO_HALVES - 1)) to_raw <= 1'b1;
      else if (wr && bus_addr == OFF_ICLR && bus_wdata[1]) to_raw <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTL0: bus_rdata = ctl0;
      OFF_CTL1: bus_rdata = 16'(ctl1);
      OFF_DATA: bus_rdata = rx_empty ? '0 : 16'(rx_dout);
      OFF_STAT: bus_rdata = 16'(status);
      OFF_PRE:  bus_rdata = 16'(pre);
      OFF_IMSK: bus_rdata = 16'(imsk);
      OFF_RAW:  bus_rdata = 16'(raw);
      OFF_MSK:  bus_rdata = 16'(masked);
      default:  bus_rdata = '0;
    endcase
  end

  AST_FRAME_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fs_n) |-> $past(!tx_empty)); // R2
  AST_OVERRUN_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_raw) |-> $past(rx_full)); // R9
  AST_TIMEOUT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_raw) |-> !rx_empty); // R10
endmodule

// File: tb/tb_ssp_master.sv
module tb_ssp_master;
  typedef struct packed {
    logic [1:0]  mode;
    logic        wide;
    logic [7:0]  pre;
    logic [7:0]  rate;
    logic [15:0] tx;
    logic [15:0] sl;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 1'b0, 8'd2, 8'd0, 16'h00A5, 16'h003C},
    '{2'd1, 1'b0, 8'd4, 8'd1, 16'h005A, 16'h00C3},
    '{2'd2, 1'b1, 8'd2, 8'd2, 16'hBEEF, 16'h1234},
    '{2'd3, 1'b1, 8'd6, 8'd0, 16'h8001, 16'hF00F},
    '{2'd3, 1'b0, 8'd3, 8'd0, 16'h0081, 16'h007E},
    '{2'd0, 1'b1, 8'd2, 8'd3, 16'h0F0F, 16'hAAAA}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi, miso, fs_n, irq;
  int checks = 0, errors = 0;

  logic mon_cpol = 1'b0, mon_cpha = 1'b0;
  int mon_n = 8;
  logic [15:0] slave_word = '0, mon_cap = '0;
  int out_cnt = 0, fs_cnt = 0, bit_idx;
  logic sclk_prev = 1'b0, fs_prev = 1'b1;

  always #4 clk = ~clk;

  ssp_master dut (.clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata,
    .bus_rdata, .sclk, .mosi, .miso, .fs_n, .irq);

  always_comb begin
    bit_idx = mon_cpha ? out_cnt - 1 : out_cnt;
    if (bit_idx < 0) bit_idx = 0;
    if (bit_idx > mon_n - 1) bit_idx = mon_n - 1;
    miso = slave_word[mon_n - 1 - bit_idx];
  end

  always @(negedge clk) begin
    if (fs_prev && !fs_n) begin
      fs_cnt = 1; mon_cap = '0; out_cnt = 0;
    end else if (!fs_n) fs_cnt = fs_cnt + 1;
    if ((!fs_n || !fs_prev) && sclk != sclk_prev) begin
      if ((sclk != mon_cpol) == !mon_cpha) mon_cap = {mon_cap[14:0], mosi};
      else out_cnt = out_cnt + 1;
    end
    sclk_prev = sclk;
    fs_prev = fs_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int k = 0; k < 5000; k++) begin
      rd(6'h0C, s);
      if (!s[4]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n, h;
    logic [15:0] m;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 fs_n", 32'(fs_n), 1);
    chk("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    rd(6'h0C, v); chk("R1 status", 32'(v), 32'h0B);
    rd(6'h00, v); chk("R1 ctl0", 32'(v), 0);

    // R3 R4 R5: vector table
    foreach (VECS[i]) begin
      n = VECS[i].wide ? 16 : 8;
      h = ((VECS[i].pre >> 1) == 0 ? 1 : int'(VECS[i].pre >> 1)) * (int'(VECS[i].rate) + 1);
      m = VECS[i].wide ? 16'hFFFF : 16'h00FF;
      wr(6'h04, 16'h0000);
      wr(6'h00, {VECS[i].rate, VECS[i].mode[0], VECS[i].mode[1], 2'b00, VECS[i].wide ? 4'd15 : 4'd7});
      wr(6'h10, 16'(VECS[i].pre));
      mon_cpol = VECS[i].mode[1]; mon_cpha = VECS[i].mode[0]; mon_n = n;
      slave_word = VECS[i].sl & m;
      wr(6'h08, VECS[i].tx);
      chk("R5 idle clock level", 32'(sclk), 32'(VECS[i].mode[1]));
      wr(6'h04, 16'h0002);
      wait_idle();
      chk("R3 frame length", 32'(fs_cnt), 32'(2 * n * h));
      chk("R4 R5 mosi bits", 32'(mon_cap & m), 32'(VECS[i].tx & m));
      rd(6'h08, v); chk("R4 R5 received word", 32'(v), 32'(VECS[i].sl & m));
    end

    // R13 R6: stored-only bits, loopback ignores miso
    wr(6'h04, 16'h000C);
    rd(6'h04, v); chk("R13 ctl1 readback", 32'(v), 32'h0C);
    wr(6'h00, 16'h0037);
    wr(6'h10, 16'h0002);
    rd(6'h00, v); chk("R13 ctl0 readback", 32'(v), 32'h37);
    mon_cpol = 1'b0; mon_cpha = 1'b0; mon_n = 8; slave_word = 16'h00FF;
    wr(6'h04, 16'h000F);
    wr(6'h08, 16'h005A);
    wait_idle();
    rd(6'h08, v); chk("R6 R13 loopback word", 32'(v), 32'h5A);

    // R7: disabled port queues writes, starts no frame
    wr(6'h04, 16'h0001);
    for (int k = 0; k < 3; k++) wr(6'h08, 16'(16'h10 + k));
    rd(6'h0C, v); chk("R7 R2 status disabled", 32'(v), 32'h1A);
    repeat (50) @(negedge clk);
    chk("R7 fs_n high", 32'(fs_n), 1);
    chk("R7 sclk at polarity", 32'(sclk), 0);
    rd(6'h18, v); chk("R12 tx request at 3", 32'(v[3]), 1);

    // R8: 9th write dropped, order kept
    for (int k = 3; k < 9; k++) wr(6'h08, 16'(16'h10 + k));
    rd(6'h0C, v); chk("R8 R2 tx full status", 32'(v), 32'h18);
    rd(6'h18, v); chk("R12 no tx request at 8", 32'(v[3]), 0);
    wr(6'h04, 16'h0003);
    wait_idle();
    rd(6'h0C, v); chk("R8 R2 rx full status", 32'(v), 32'h07);
    rd(6'h18, v); chk("R12 requests", 32'(v[3:2]), 32'h3);
    // R9: frame into full receive queue
    wr(6'h08, 16'h0099);
    wait_idle();
    rd(6'h18, v); chk("R9 overrun raw", 32'(v[0]), 1);
    for (int k = 0; k < 8; k++) begin
      rd(6'h08, v); chk("R8 R9 receive order", 32'(v), 32'(16'h10 + k));
    end
    rd(6'h0C, v); chk("R8 rx empty", 32'(v[2]), 0);
    // R11: clear affects only bits 0 and 1
    wr(6'h20, 16'h000F);
    rd(6'h18, v); chk("R11 clear", 32'(v), 32'h8);

    // R10 R12: timeout and masking
    wr(6'h08, 16'h0042);
    wait_idle();
    repeat (10) @(negedge clk);
    rd(6'h18, v); chk("R10 no early timeout", 32'(v[1]), 0);
    repeat (100) @(negedge clk);
    rd(6'h18, v); chk("R10 timeout raw", 32'(v[1]), 1);
    chk("R12 irq masked off", 32'(irq), 0);
    wr(6'h14, 16'h0002);
    rd(6'h1C, v); chk("R12 masked status", 32'(v), 32'h2);
    chk("R12 irq on", 32'(irq), 1);
    wr(6'h20, 16'h0002);
    rd(6'h18, v); chk("R11 timeout cleared", 32'(v[1]), 0);
    chk("R12 irq off after clear", 32'(irq), 0);
    rd(6'h08, v); chk("R6 loopback word", 32'(v), 32'h42);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule